// File: doc/BRIEF.md
# Display Mode Latch Bank

This block holds eight single-bit display mode controls that software sets through one byte-wide write port. Every write strobe carries an index in data bits 3:1 and a new value in data bit 0. Most indices load the selected bit directly. The vertical-resolution control at index 4 is guarded: a write to index 1 arms it, and only the next index-4 write after arming is accepted. Index 1 never stores a value of its own.

All eight bits are available as registered mode outputs for the rest of the display system. The named controls are attribute select (bit 0), font height (bit 3, 0 for 8 lines and 1 for 16 lines), memory switch (bit 6) and display enable (bit 7). The memory-switch bit also gates word writes into the top part of text memory. A companion output passes a text write request through only when it falls below the protected boundary, or when the memory switch is set. A 3-bit debug output reports the index carried by the most recent write.

Top module: `mode_latch_bank`

## Requirements
- R1: A synchronous active-high reset clears all eight mode bits, the arm flag and the debug index to 0. After reset, an index-4 write with no prior arming leaves bit 4 at 0.
- R2: A write with index field wr_data[3:1] equal to 0, 2, 3, 5, 6 or 7 loads wr_data[0] into mode_q at that index. The new value is visible on mode_q in the cycle after the strobe.
- R3: A write with index 1 changes no mode bit, and mode_q[1] stays 0. The write sets the arm flag.
- R4: A write with index 4 while the arm flag is clear is ignored, and mode_q is unchanged.
- R5: A write with index 4 while the arm flag is set loads wr_data[0] into mode_q[4] and clears the flag. A second index-4 write without a new arming write is therefore ignored.
- R6: The arm flag survives any number of writes to indices other than 1 and 4.
- R7: With wr_en low, mode_q holds its value. A write changes only the bit it selects.
- R8: txt_wr_ok is high exactly when txt_wr_req is high and either txt_wr_addr is below the protected word boundary (default 0x1FF1) or mode_q[6] is 1. It responds in the same cycle.
- R9: last_idx shows the index field of the most recent write from the cycle after the strobe. This includes arming writes and ignored writes.
- R10: Data bits 7:4 have no effect on which bit is selected or on the value loaded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Bits 3:1 index, bit 0 value, bits 7:4 ignored |
| txt_wr_req | input | 1 | Text memory word write request |
| txt_wr_addr | input | TXT_AW (13) | Text memory word address of the request |
| mode_q | output | 8 | Registered mode bits, bit i is latch i |
| txt_wr_ok | output | 1 | Request passed by the protection gate |
| last_idx | output | 3 | Index field of the most recent write |

## Verification
The bench builds the block with its default parameters: arming index 1, guarded index 4, memory switch at index 6, a 13-bit text word address and a boundary of 0x1FF1. This makes the highest unprotected address, the boundary itself and the top word directly reachable. A vector table walks an ordered sequence in which arming, consumption, a stale second guarded write and arming that survives other writes all occur. Directed steps then probe the protection boundary on both sides of the memory switch, and check that a reset taken while armed drops the pending arm.

// File: rtl/mode_latch_pkg.sv
package mode_latch_pkg;
  localparam int IDX_W   = 3;
  localparam int N_LATCH = 1 << IDX_W;

  typedef struct packed {
    logic             hit;     // strobe present
    logic [IDX_W-1:0] idx;     // selected latch
    logic             val;     // value bit
    logic             arm_hit; // write to arming index
    logic             gate_hit;// write to guarded index
  } wr_dec_t;
endpackage

// File: rtl/mode_wr_decode.sv
module mode_wr_decode
  import mode_latch_pkg::*;
#(
  parameter int SEL_LSB  = 1,
  parameter int ARM_IDX  = 1,
  parameter int GATE_IDX = 4
) (
  input  logic                 wr_en,
  input  logic [SEL_LSB+IDX_W-1:0] sel_field,
  output wr_dec_t              dec
);
  always_comb begin
    dec.hit      = wr_en;
    dec.idx      = sel_field[SEL_LSB +: IDX_W];
    dec.val      = sel_field[0];
    dec.arm_hit  = wr_en && (dec.idx == IDX_W'(ARM_IDX));
    dec.gate_hit = wr_en && (dec.idx == IDX_W'(GATE_IDX));
  end
endmodule

// File: rtl/mode_arm_ctrl.sv
module mode_arm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic arm_hit,
  input  logic gate_hit,
  output logic armed
);
  always_ff @(posedge clk) begin
    if (rst)
      armed <= 1'b0;
    else if (arm_hit)
      armed <= 1'b1;
    else if (gate_hit && armed)
      armed <= 1'b0;
  end
endmodule

// File: rtl/txt_protect_gate.sv
module txt_protect_gate #(
  parameter int TXT_AW        = 13,
  parameter int TXT_PROT_BASE = 'h1FF1
) (
  input  logic              req,
  input  logic [TXT_AW-1:0] addr,
  input  logic              unlock,
  output logic              ok
);
  localparam logic [TXT_AW-1:0] BASE = TXT_AW'(TXT_PROT_BASE);

  always_comb ok = req && ((addr < BASE) || unlock);
endmodule

// File: rtl/mode_latch_bank.sv
module mode_latch_bank
  import mode_latch_pkg::*;
#(
  parameter int SEL_LSB       = 1,
  parameter int ARM_IDX       = 1,
  parameter int GATE_IDX      = 4,
  parameter int MEMSW_IDX     = 6,
  parameter int TXT_AW        = 13,
  parameter int TXT_PROT_BASE = 'h1FF1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              txt_wr_req,
  input  logic [TXT_AW-1:0] txt_wr_addr,
  output logic [7:0]        mode_q,
  output logic              txt_wr_ok,
  output logic [IDX_W-1:0]  last_idx
);
  localparam int FIELD_W = SEL_LSB + IDX_W;

  wr_dec_t dec;
  logic    armed;

  mode_wr_decode #(
    .SEL_LSB(SEL_LSB), .ARM_IDX(ARM_IDX), .GATE_IDX(GATE_IDX)
  ) u_dec (
    .wr_en    (wr_en),
    .sel_field(wr_data[FIELD_W-1:0]),
    .dec      (dec)
  );

  mode_arm_ctrl u_arm (
    .clk     (clk),
    .rst     (rst),
    .arm_hit (dec.arm_hit),
    .gate_hit(dec.gate_hit),
    .armed   (armed)
  );

  for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
    if (i == ARM_IDX) begin : g_arm_slot
      // arming index stores nothing
      always_ff @(posedge clk) mode_q[i] <= 1'b0;
    end else if (i == GATE_IDX) begin : g_guarded
      always_ff @(posedge clk) begin
        if (rst)
          mode_q[i] <= 1'b0;
        else if (dec.gate_hit && armed)
          mode_q[i] <= dec.val;
      end
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst)
          mode_q[i] <= 1'b0;
        else if (dec.hit && dec.idx == IDX_W'(i))
          mode_q[i] <= dec.val;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      last_idx <= '0;
    else if (dec.hit)
      last_idx <= dec.idx;
  end

  txt_protect_gate #(
    .TXT_AW(TXT_AW), .TXT_PROT_BASE(TXT_PROT_BASE)
  ) u_prot (
    .req   (txt_wr_req),
    .addr  (txt_wr_addr),
    .unlock(mode_q[MEMSW_IDX]),
    .ok    (txt_wr_ok)
  );
endmodule

// File: rtl/mode_latch_bank_chk.sv
module mode_latch_bank_chk #(
  parameter int ARM_IDX       = 1,
  parameter int GATE_IDX      = 4,
  parameter int TXT_AW        = 13,
  parameter int TXT_PROT_BASE = 'h1FF1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [7:0]        wr_data,
  input logic              armed,
  input logic [7:0]        mode_q,
  input logic [2:0]        last_idx,
  input logic              txt_wr_req,
  input logic [TXT_AW-1:0] txt_wr_addr,
  input logic              txt_wr_ok
);
  localparam logic [2:0] AI = 3'(ARM_IDX);
  localparam logic [2:0] GI = 3'(GATE_IDX);
  localparam logic [TXT_AW-1:0] BASE = TXT_AW'(TXT_PROT_BASE);

  // R2
  a_r2_direct_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3:1] != AI && wr_data[3:1] != GI)
      |=> mode_q[$past(wr_data[3:1])] == $past(wr_data[0]));
  // R3
  a_r3_arm_no_store: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3:1] == AI) |=> ($stable(mode_q) && armed));
  // R4
  a_r4_unarmed_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3:1] == GI && !armed) |=> $stable(mode_q));
  // R5
  a_r5_armed_consumed: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[3:1] == GI && armed)
      |=> (!armed && mode_q[GATE_IDX] == $past(wr_data[0])));
  // R6
  a_r6_arm_held: assert property (@(posedge clk) disable iff (rst)
    (armed && !(wr_en && wr_data[3:1] == GI)) |=> armed);
  // R7
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode_q));
  // R7
  a_r7_single_bit: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> $countones(mode_q ^ $past(mode_q)) <= 1);
  // R8
  a_r8_low_region_open: assert property (@(posedge clk) disable iff (rst)
    (txt_wr_req && txt_wr_addr < BASE) |-> txt_wr_ok);
  // R8
  a_r8_high_region_locked: assert property (@(posedge clk) disable iff (rst)
    (txt_wr_addr >= BASE && !mode_q[6]) |-> !txt_wr_ok);
  // R9
  a_r9_last_index: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> last_idx == $past(wr_data[3:1]));
endmodule

bind mode_latch_bank mode_latch_bank_chk #(
  .ARM_IDX(ARM_IDX), .GATE_IDX(GATE_IDX),
  .TXT_AW(TXT_AW), .TXT_PROT_BASE(TXT_PROT_BASE)
) u_chk (.*);

// File: tb/tb_mode_latch_bank.sv
module tb_mode_latch_bank;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 13;

  logic          clk = 1'b0;
  logic          rst;
  logic          wr_en;
  logic [7:0]    wr_data;
  logic          txt_wr_req;
  logic [AW-1:0] txt_wr_addr;
  logic [7:0]    mode_q;
  logic          txt_wr_ok;
  logic [2:0]    last_idx;

  int n_chk = 0;
  int n_bad = 0;

  mode_latch_bank dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .txt_wr_req(txt_wr_req), .txt_wr_addr(txt_wr_addr),
    .mode_q(mode_q), .txt_wr_ok(txt_wr_ok), .last_idx(last_idx)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // entry: {req_tag[3:0], wr_en, data[7:0], exp_mode[7:0], exp_last[2:0]}
  localparam int NV = 15;
  localparam logic [23:0] VEC [NV] = '{
    {4'd2,  1'b1, 8'h0F, 8'h80, 3'd7}, // R2 display enable on
    {4'd2,  1'b1, 8'h07, 8'h88, 3'd3}, // R2 tall font
    {4'd4,  1'b1, 8'h09, 8'h88, 3'd4}, // R4 unarmed guarded write
    {4'd3,  1'b1, 8'h03, 8'h88, 3'd1}, // R3 arm, nothing stored
    {4'd6,  1'b1, 8'h0D, 8'hC8, 3'd6}, // R6 other write keeps arm
    {4'd5,  1'b1, 8'h09, 8'hD8, 3'd4}, // R5 armed guarded write
    {4'd5,  1'b1, 8'h08, 8'hD8, 3'd4}, // R5 arm consumed, ignored
    {4'd10, 1'b1, 8'hF1, 8'hD9, 3'd0}, // R10 high bits ignored
    {4'd7,  1'b0, 8'h0E, 8'hD9, 3'd0}, // R7 no strobe
    {4'd2,  1'b1, 8'h0E, 8'h59, 3'd7}, // R2 clear bit 7
    {4'd3,  1'b1, 8'h02, 8'h59, 3'd1}, // R3 arm with value 0
    {4'd10, 1'b1, 8'hE8, 8'h49, 3'd4}, // R10 guarded clear, high bits set
    {4'd2,  1'b1, 8'h0C, 8'h09, 3'd6}, // R2 clear memory switch
    {4'd9,  1'b1, 8'h05, 8'h0D, 3'd2}, // R9 index 2
    {4'd9,  1'b1, 8'h0B, 8'h2D, 3'd5}  // R9 index 5
  };

  task automatic chk_mode(input string tag, input logic [7:0] em, input logic [2:0] el);
    n_chk++;
    if (mode_q !== em || last_idx !== el) begin
      n_bad++;
      $display("FAIL %s mode=%02h last=%0d expected mode=%02h last=%0d",
               tag, mode_q, last_idx, em, el);
    end
  endtask

  task automatic chk_ok(input string tag, input logic e);
    n_chk++;
    if (txt_wr_ok !== e) begin
      n_bad++;
      $display("FAIL %s txt_wr_ok=%0b expected %0b", tag, txt_wr_ok, e);
    end
  endtask

  task automatic do_wr(input logic en, input logic [7:0] d);
    @(negedge clk);
    wr_en = en; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input logic rq, input logic [AW-1:0] a);
    txt_wr_req = rq; txt_wr_addr = a;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    rst = 1'b1; wr_en = 1'b0; wr_data = '0; txt_wr_req = 1'b0; txt_wr_addr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_mode("R1 reset state", 8'h00, 3'd0);

    for (int v = 0; v < NV; v++) begin
      do_wr(VEC[v][19], VEC[v][18:11]);
      chk_mode($sformatf("R%0d vector %0d", VEC[v][23:20], v), VEC[v][10:3], VEC[v][2:0]);
    end

    // R8 memory switch clear (mode 0x2D)
    probe(1'b1, 13'h1FF0); chk_ok("R8 below boundary", 1'b1);
    probe(1'b1, 13'h1FF1); chk_ok("R8 at boundary locked", 1'b0);
    probe(1'b1, 13'h1FFF); chk_ok("R8 top word locked", 1'b0);
    probe(1'b0, 13'h0000); chk_ok("R8 no request", 1'b0);
    do_wr(1'b1, 8'h0D);    // memory switch on
    probe(1'b1, 13'h1FF1); chk_ok("R8 at boundary unlocked", 1'b1);
    probe(1'b1, 13'h1FFF); chk_ok("R8 top word unlocked", 1'b1);
    probe(1'b0, 13'h0000);

    // R1 reset drops a pending arm
    do_wr(1'b1, 8'h03);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk_mode("R1 reset mid-run", 8'h00, 3'd0);
    do_wr(1'b1, 8'h09);
    chk_mode("R1 arm cleared by reset", 8'h00, 3'd4);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule